// File: doc/BRIEF.md
# DVMA Page-Table Address Translator

This block turns a device-side transfer request (start address, byte count, read or write) into a sequence of physical chunks. For every 4 KB page touched by the transfer it reads one 32-bit translation entry from memory through a request/response read port. It then checks the entry's permission bits and presents one chunk carrying a 36-bit physical address and a byte length. A downstream data mover consumes each chunk through a valid/ready handshake.

Entries live in a linear table. The table's origin comes from a base input that is scaled by 16. The table is indexed by the page number of the address once the bits of the translation window are cleared. A missing entry, or a write to a page that is not writable, ends the transfer at once. The block then raises a one-cycle fault pulse and holds a status word and the page address of the failed page until the next fault.

Top module: `dvma_xlate`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1; `mem_rd_valid`, `chunk_valid`, `done` and `fault` are 0; `fault_status` and `fault_addr` are 0.
- R2: The entry for address A is read at `{tbl_base, 4'b0} + (((A & ~win_mask) >> 12) << 2)`, one read per page touched.
- R3: A chunk's physical address is `{entry[31:8], A[11:0]}` (36 bits), and `chunk_cache` carries entry bit 7.
- R4: Each chunk length is the smaller of the bytes still to move and `4096 - A[11:0]`; no chunk is empty or crosses a 4 KB boundary.
- R5: Chunks come out in ascending address order, each starting where the previous one ended. `done` pulses for one cycle after the last chunk is accepted.
- R6: An entry with bit 1 (valid) clear stops the transfer: no chunk for that page, no further reads or chunks, and one `fault` pulse instead of `done`.
- R7: For a write, an entry with bit 2 (writable) clear causes a fault as in R6. For a read, bit 2 is ignored.
- R8: On a fault, `fault_status` is 0xC0860000 for a read and 0xC0820000 for a write. These are bits 31, 30, 23 and 17, plus bit 18 for a read. `fault_addr` is the failing address with bits [11:0] cleared.
- R9: A zero-length request yields a `done` pulse with no entry read and no chunk.
- R10: `chunk_valid` with its address, length and cache flag, and `mem_rd_valid` with its address, stay stable until their ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_addr | input | 32 | Device virtual start address |
| req_len | input | 16 | Transfer byte count |
| req_write | input | 1 | 1 = write transfer, 0 = read |
| tbl_base | input | 32 | Table base, scaled by 16 to form the table origin |
| win_mask | input | 32 | Address bits forming the window start, cleared before indexing |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 36 | Entry byte address |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 32 | Entry word |
| chunk_valid | output | 1 | Chunk present |
| chunk_ready | input | 1 | Chunk consumed |
| chunk_pa | output | 36 | Chunk physical address |
| chunk_len | output | 16 | Chunk byte count |
| chunk_cache | output | 1 | Entry cacheable flag |
| done | output | 1 | One-cycle pulse, transfer completed |
| fault | output | 1 | One-cycle pulse, transfer aborted |
| fault_status | output | 32 | Status word of the last fault |
| fault_addr | output | 32 | Page address of the last fault |

## Verification
The bound checker watches every cycle for handshake stability on both the chunk and entry-read ports. It also checks that no chunk is empty or crosses a page, that `done` and `fault` never coincide and last one cycle, and that the fault word always carries its fixed bits with a page-aligned address. Only the directed scenarios can show the values themselves. These are the entry addresses read, the translated addresses and split lengths, the exact status code for reads versus writes, the point at which a fault cuts a transfer short, and the silence of a zero-length request.

// File: rtl/dvma_pkg.sv
package dvma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_CHECK,
    ST_EMIT,
    ST_DONE,
    ST_FAULT
  } xl_state_t;

  // entry bit positions
  localparam int PTE_VALID_BIT = 1;
  localparam int PTE_WRITE_BIT = 2;
  localparam int PTE_CACHE_BIT = 7;
  localparam int PTE_PPN_LSB   = 8;

  // fault status composition
  localparam logic [31:0] FSTAT_FIXED = 32'hC082_0000;
  localparam logic [31:0] FSTAT_READ  = 32'h0004_0000;

  function automatic logic [31:0] fault_word(input logic is_read);
    return FSTAT_FIXED | (is_read ? FSTAT_READ : 32'h0);
  endfunction

endpackage

// File: rtl/dvma_pte_addr.sv
module dvma_pte_addr #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 36,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [VA_W-1:0]   va,
  input  logic [VA_W-1:0]   win_mask,
  input  logic [PA_W-5:0]   base,
  output logic [PA_W-1:0]   entry_addr
);
  logic [VA_W-1:0] rel;
  logic [VA_W-1:0] page_idx;

  always_comb begin
    rel        = va & ~win_mask;
    page_idx   = rel >> PAGE_SHIFT;
    entry_addr = {base, 4'b0000} + (PA_W'(page_idx) << 2);
  end
endmodule

// File: rtl/dvma_chunk_calc.sv
module dvma_chunk_calc #(
  parameter int LEN_W      = 16,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [PAGE_SHIFT-1:0] offset,
  input  logic [LEN_W-1:0]      remaining,
  output logic [LEN_W-1:0]      len
);
  localparam int CW = (LEN_W > PAGE_SHIFT + 1) ? LEN_W : PAGE_SHIFT + 1;
  localparam logic [CW-1:0] PAGE_BYTES = CW'(1) << PAGE_SHIFT;

  logic [CW-1:0] to_edge;
  logic [CW-1:0] rem_w;

  always_comb begin
    to_edge = PAGE_BYTES - CW'(offset);
    rem_w   = CW'(remaining);
    len     = (rem_w < to_edge) ? remaining : LEN_W'(to_edge);
  end
endmodule

// File: rtl/dvma_pte_check.sv
module dvma_pte_check
  import dvma_pkg::*;
#(
  parameter int PA_W       = 36,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [31:0]           pte,
  input  logic                  is_write,
  input  logic [PAGE_SHIFT-1:0] offset,
  output logic                  bad,
  output logic                  cacheable,
  output logic [PA_W-1:0]       pa
);
  localparam int PPN_W = PA_W - PAGE_SHIFT;

  always_comb begin
    bad       = !pte[PTE_VALID_BIT] || (is_write && !pte[PTE_WRITE_BIT]);
    cacheable = pte[PTE_CACHE_BIT];
    pa        = {pte[PTE_PPN_LSB +: PPN_W], offset};
  end
endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate
  import dvma_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 36,
  parameter int LEN_W      = 16,
  parameter int PAGE_SHIFT = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_write,
  input  logic [PA_W-5:0]  tbl_base,
  input  logic [VA_W-1:0]  win_mask,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  output logic             chunk_valid,
  input  logic             chunk_ready,
  output logic [PA_W-1:0]  chunk_pa,
  output logic [LEN_W-1:0] chunk_len,
  output logic             chunk_cache,
  output logic             done,
  output logic             fault,
  output logic [31:0]      fault_status,
  output logic [VA_W-1:0]  fault_addr
);
  localparam logic [VA_W-1:0] PAGE_MASK = ~((VA_W'(1) << PAGE_SHIFT) - VA_W'(1));

  xl_state_t        state;
  logic [VA_W-1:0]  cur_addr;
  logic [LEN_W-1:0] remaining;
  logic             is_write;
  logic [31:0]      pte_q;
  logic [PA_W-1:0]  rd_addr_q;
  logic [PA_W-1:0]  pa_q;
  logic [LEN_W-1:0] len_q;
  logic             cache_q;
  logic [31:0]      fstat_q;
  logic [VA_W-1:0]  faddr_q;

  // address that the next entry read is formed from
  logic [VA_W-1:0]  next_va;
  logic [PA_W-1:0]  next_entry;
  logic [LEN_W-1:0] calc_len;
  logic             pte_bad;
  logic             pte_cache;
  logic [PA_W-1:0]  pte_pa;

  assign next_va = (state == ST_IDLE) ? req_addr : (cur_addr + VA_W'(len_q));

  dvma_pte_addr #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_addr (
    .va        (next_va),
    .win_mask  (win_mask),
    .base      (tbl_base),
    .entry_addr(next_entry)
  );

  dvma_chunk_calc #(.LEN_W(LEN_W), .PAGE_SHIFT(PAGE_SHIFT)) u_split (
    .offset   (cur_addr[PAGE_SHIFT-1:0]),
    .remaining(remaining),
    .len      (calc_len)
  );

  dvma_pte_check #(.PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_chk_pte (
    .pte      (pte_q),
    .is_write (is_write),
    .offset   (cur_addr[PAGE_SHIFT-1:0]),
    .bad      (pte_bad),
    .cacheable(pte_cache),
    .pa       (pte_pa)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_addr  <= '0;
      remaining <= '0;
      is_write  <= 1'b0;
      pte_q     <= '0;
      rd_addr_q <= '0;
      pa_q      <= '0;
      len_q     <= '0;
      cache_q   <= 1'b0;
      fstat_q   <= '0;
      faddr_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_addr  <= req_addr;
            remaining <= req_len;
            is_write  <= req_write;
            rd_addr_q <= next_entry;
            state     <= (req_len == '0) ? ST_DONE : ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_rd_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            pte_q <= mem_rsp_data;
            state <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (pte_bad) begin
            fstat_q <= fault_word(!is_write);
            faddr_q <= cur_addr & PAGE_MASK;
            state   <= ST_FAULT;
          end else begin
            pa_q    <= pte_pa;
            len_q   <= calc_len;
            cache_q <= pte_cache;
            state   <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (chunk_ready) begin
            cur_addr  <= next_va;
            remaining <= remaining - len_q;
            rd_addr_q <= next_entry;
            state     <= (remaining == len_q) ? ST_DONE : ST_FETCH;
          end
        end
        ST_DONE:  state <= ST_IDLE;
        ST_FAULT: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state == ST_IDLE);
  assign mem_rd_valid = (state == ST_FETCH);
  assign mem_rd_addr  = rd_addr_q;
  assign chunk_valid  = (state == ST_EMIT);
  assign chunk_pa     = pa_q;
  assign chunk_len    = len_q;
  assign chunk_cache  = cache_q;
  assign done         = (state == ST_DONE);
  assign fault        = (state == ST_FAULT);
  assign fault_status = fstat_q;
  assign fault_addr   = faddr_q;

endmodule

// File: rtl/dvma_xlate_chk.sv
module dvma_xlate_chk #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 36,
  parameter int LEN_W      = 16,
  parameter int PAGE_SHIFT = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic             mem_rd_valid,
  input logic             mem_rd_ready,
  input logic [PA_W-1:0]  mem_rd_addr,
  input logic             chunk_valid,
  input logic             chunk_ready,
  input logic [PA_W-1:0]  chunk_pa,
  input logic [LEN_W-1:0] chunk_len,
  input logic             chunk_cache,
  input logic             done,
  input logic             fault,
  input logic [31:0]      fault_status,
  input logic [VA_W-1:0]  fault_addr
);
  localparam int PAGE_BYTES = 1 << PAGE_SHIFT;

  assert_chunk_hold_R10: assert property (@(posedge clk) disable iff (rst)
    chunk_valid && !chunk_ready |=> chunk_valid && $stable(chunk_pa) &&
                                    $stable(chunk_len) && $stable(chunk_cache));

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  assert_chunk_in_page_R4: assert property (@(posedge clk) disable iff (rst)
    chunk_valid |-> (chunk_len != '0) &&
      (32'(chunk_pa[PAGE_SHIFT-1:0]) + 32'(chunk_len) <= 32'(PAGE_BYTES)));

  assert_end_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && req_ready);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_rd_valid && !chunk_valid);

  assert_fault_word_R8: assert property (@(posedge clk) disable iff (rst)
    fault |-> fault_status[31] && fault_status[30] && fault_status[23] &&
              fault_status[17] && (fault_addr[PAGE_SHIFT-1:0] == '0));

endmodule

bind dvma_xlate dvma_xlate_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .LEN_W(LEN_W), .PAGE_SHIFT(PAGE_SHIFT)
) u_xlate_chk (.*);

// File: tb/sim_dvma_xlate.sv
`timescale 1ns/1ps
module sim_dvma_xlate;
  localparam int VA_W = 32, PA_W = 36, LEN_W = 16;
  localparam logic [31:0] WIN   = 32'hFF00_0000;
  localparam logic [31:0] BASE  = 32'h0001_0000;
  localparam logic [35:0] TBL0  = {BASE, 4'b0000};

  logic clk = 0, rst = 1;
  always #4 clk = ~clk;

  logic             req_valid = 0, req_ready, req_write = 0;
  logic [31:0]      req_addr = 0;
  logic [15:0]      req_len = 0;
  logic             mem_rd_valid, mem_rd_ready = 1;
  logic [35:0]      mem_rd_addr;
  logic             mem_rsp_valid = 0;
  logic [31:0]      mem_rsp_data = 0;
  logic             chunk_valid, chunk_ready = 1, chunk_cache, done, fault;
  logic [35:0]      chunk_pa;
  logic [15:0]      chunk_len;
  logic [31:0]      fault_status, fault_addr;

  dvma_xlate u0 (
    .clk, .rst, .req_valid, .req_ready, .req_addr, .req_len, .req_write,
    .tbl_base(BASE), .win_mask(WIN),
    .mem_rd_valid, .mem_rd_ready, .mem_rd_addr, .mem_rsp_valid, .mem_rsp_data,
    .chunk_valid, .chunk_ready, .chunk_pa, .chunk_len, .chunk_cache,
    .done, .fault, .fault_status, .fault_addr
  );

  int checks = 0, failures = 0;
  logic [31:0] pte_tbl [16];
  int latency = 0;
  bit stall = 0;
  int cyc = 0;

  // logs
  logic [35:0] fetch_log [256];
  logic [35:0] pa_log    [256];
  int          len_log   [256];
  bit          cache_log [256];
  int nf = 0, nc = 0, ndone = 0, nfault = 0;
  bit pend = 0;
  int cnt = 0;
  int idx_q = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rd_ready <= stall ? (cyc % 3 == 2) : 1'b1;
    chunk_ready  <= stall ? (cyc % 4 == 1) : 1'b1;
    if (mem_rsp_valid) mem_rsp_valid <= 1'b0;
    if (mem_rd_valid && mem_rd_ready) begin
      fetch_log[nf] <= mem_rd_addr;
      nf    <= nf + 1;
      pend  <= 1;
      cnt   <= latency;
      idx_q <= int'((mem_rd_addr - TBL0) >> 2) & 15;
    end else if (pend) begin
      if (cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= pte_tbl[idx_q];
        pend <= 0;
      end else cnt <= cnt - 1;
    end
    if (chunk_valid && chunk_ready) begin
      pa_log[nc] <= chunk_pa; len_log[nc] <= int'(chunk_len);
      cache_log[nc] <= chunk_cache; nc <= nc + 1;
    end
    if (done)  ndone  <= ndone + 1;
    if (fault) nfault <= nfault + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // run one transfer and compare against a model built from the requirements
  task automatic run_xfer(input string req, input logic [31:0] addr,
                          input int len, input bit wr);
    int f0 = nf, c0 = nc, d0 = ndone, x0 = nfault;
    int exp_c = 0, exp_f = 0, rem = len, l, pg;
    bit exp_fault = 0;
    logic [31:0] a = addr, p;
    int waitc = 0;
    @(negedge clk);
    req_addr = addr; req_len = 16'(len); req_write = wr; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (ndone == d0 && nfault == x0 && waitc < 3000) begin
      @(negedge clk); waitc++;
    end
    while (rem > 0) begin
      pg = int'(((a & ~WIN) >> 12));
      p  = pte_tbl[pg & 15];
      // R2: entry address
      chk(fetch_log[f0+exp_f] == TBL0 + 36'(pg * 4), "R2", "entry addr",
          fetch_log[f0+exp_f], TBL0 + 36'(pg * 4));
      exp_f++;
      if (!p[1] || (wr && !p[2])) begin exp_fault = 1; break; end
      l = 4096 - int'(a[11:0]);
      if (rem < l) l = rem;
      chk(pa_log[c0+exp_c] == {p[31:8], a[11:0]}, req, "R3 chunk pa",
          pa_log[c0+exp_c], {p[31:8], a[11:0]});
      chk(len_log[c0+exp_c] == l, req, "R4 chunk len", len_log[c0+exp_c], l);
      chk(cache_log[c0+exp_c] == p[7], req, "R3 cache flag",
          cache_log[c0+exp_c], p[7]);
      exp_c++; rem -= l; a += l;
    end
    chk(nc - c0 == exp_c, req, "R5 chunk count", nc - c0, exp_c);
    chk(nf - f0 == exp_f, req, "R6 fetch count", nf - f0, exp_f);
    chk(ndone - d0 == (exp_fault ? 0 : 1), req, "R5 done", ndone - d0, !exp_fault);
    chk(nfault - x0 == (exp_fault ? 1 : 0), req, "R6 fault", nfault - x0, exp_fault);
    if (exp_fault) begin
      chk(fault_status == (wr ? 32'hC082_0000 : 32'hC086_0000), req, "R8 status",
          fault_status, wr ? 32'hC082_0000 : 32'hC086_0000);
      chk(fault_addr == {a[31:12], 12'h000}, req, "R8 fault addr",
          fault_addr, {a[31:12], 12'h000});
    end
  endtask

  task automatic t_reset();
    chk(req_ready == 1, "R1", "req_ready", req_ready, 1);
    chk(!mem_rd_valid && !chunk_valid, "R1", "rd/chunk valid", {mem_rd_valid, chunk_valid}, 0);
    chk(!done && !fault, "R1", "done/fault", {done, fault}, 0);
    chk(fault_status == 0 && fault_addr == 0, "R1", "fault regs", fault_status, 0);
  endtask

  task automatic t_single_page();   run_xfer("R3", 32'hFF00_0100, 16'h80, 0); endtask
  task automatic t_cross_pages();   latency = 3; run_xfer("R4", 32'hFF00_1F00, 32'h2200, 0); latency = 0; endtask
  task automatic t_write_backpr();  stall = 1; latency = 2; run_xfer("R10", 32'hFF00_2FFC, 16'h1010, 1); stall = 0; latency = 0; endtask
  task automatic t_invalid_mid();   run_xfer("R6", 32'hFF00_5800, 16'h2000, 0); endtask
  task automatic t_write_ro();      run_xfer("R7", 32'hFF00_8010, 16'h40, 1); endtask
  task automatic t_read_ro();       run_xfer("R7", 32'hFF00_8010, 16'h40, 0); endtask
  task automatic t_zero_len();
    int f0 = nf, c0 = nc, d0 = ndone;
    @(negedge clk);
    req_addr = 32'hFF00_3000; req_len = 0; req_write = 0; req_valid = 1;
    @(negedge clk); req_valid = 0;
    repeat (4) @(negedge clk);
    chk(ndone - d0 == 1, "R9", "done pulse", ndone - d0, 1);
    chk(nf == f0 && nc == c0, "R9", "no fetch/chunk", nf - f0 + nc - c0, 0);
  endtask

  bit finished = 0;
  initial begin
    for (int i = 0; i < 16; i++)
      pte_tbl[i] = {24'h0ABC00 + 24'(i * 17), 8'h06};
    pte_tbl[2] = pte_tbl[2] | 32'h80;               // cacheable
    pte_tbl[6] = {24'h0ABC66, 8'h04};               // not valid
    pte_tbl[8] = {24'h0ABC88, 8'h02};               // read-only
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_single_page();
    t_cross_pages();
    t_write_backpr();
    t_invalid_mid();
    t_write_ro();
    t_read_ro();
    t_zero_len();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule